// File: doc/BRIEF.md
# Message Hash Feeder with Replay Cache

This block sits between a message transport and a SHA-512 block-input port. For each hash pass it sends a short header (for example an encoded point pair or a key-derived prefix) followed by the message bytes, one byte per handshake, to the hash core. It keeps an on-chip byte cache so that a message can be hashed twice without fetching all of it again from outside.

A pass is started with a mode code, a header length and a message length. In a capture pass every message byte whose offset is below the cache size is also written into the cache. A later replay pass reads those low offsets back from the cache and asks the transport only for the bytes past the cache size. Over a two-pass signing operation on an N-byte message, the external traffic is therefore N plus the part of N beyond the cache size. A single pass, used for verification, neither reads nor writes the cache. At the start of each pass the block issues a one-cycle request giving the offset and number of bytes it needs from outside. The message stream marks its final byte. An end mark that arrives early or late aborts the pass with a framing error.

Top module: `hash_replay_feeder`

## Requirements
- R1: After reset, hs_valid, busy, done, frame_err, req_valid, pfx_ready and msg_ready are all 0.
- R2: A pass first forwards exactly pfx_len header bytes in arrival order, and only after that the message bytes in offset order. msg_ready stays low while header bytes are pending.
- R3: In a capture pass (mode code 1) every message byte comes from the external stream and is forwarded unchanged. Each byte at an offset below CACHE_BYTES (4096) is stored in the cache at that offset.
- R4: In a replay pass (mode code 2) the bytes at offsets below CACHE_BYTES are read from the cache without raising msg_ready. Only the bytes at offsets CACHE_BYTES and above are taken from the external stream.
- R5: One cycle after an accepted start, req_valid pulses for one cycle if external bytes are needed. In single or capture mode req_offset is 0 and req_len is msg_len. In replay mode req_offset is CACHE_BYTES and req_len is msg_len minus CACHE_BYTES. No pulse is issued when that count is zero.
- R6: While hs_valid is high and hs_ready is low, hs_data and hs_last hold their values. No byte is dropped or repeated under any pattern of backpressure or source stalls.
- R7: hs_last is high only on the final byte of the pass. done pulses for one cycle after that byte is taken, with frame_err low.
- R8: If msg_last comes with a byte before the final offset, that byte is not forwarded. The pass then ends with done and frame_err high.
- R9: If the byte at the final offset arrives without msg_last, that byte is not forwarded. The pass then ends with done and frame_err high.
- R10: A start pulse while busy is high is ignored. The running pass completes unchanged, with one done and one request.
- R11: A single pass (mode code 0) writes nothing into the cache. A later replay still returns the bytes stored by the last capture pass.
- R12: A pass with both lengths zero forwards no byte, issues no request and pulses done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a pass (taken only when idle) |
| mode | input | 2 | 0 single, 1 capture, 2 replay (3 acts as single) |
| pfx_len | input | PFX_W | Header length in bytes |
| msg_len | input | LEN_W | Message length in bytes |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pass-end pulse |
| frame_err | output | 1 | Framing error of the last pass |
| pfx_data | input | 8 | Header byte |
| pfx_valid | input | 1 | Header byte valid |
| pfx_ready | output | 1 | Header byte taken |
| msg_data | input | 8 | External message byte |
| msg_valid | input | 1 | External byte valid |
| msg_last | input | 1 | External byte is the message end |
| msg_ready | output | 1 | External byte taken |
| req_valid | output | 1 | External fetch request pulse |
| req_offset | output | LEN_W | First message offset to fetch |
| req_len | output | LEN_W | Number of bytes to fetch |
| hs_data | output | 8 | Byte to the hash core |
| hs_valid | output | 1 | Hash byte valid |
| hs_last | output | 1 | Final byte of the pass |
| hs_ready | input | 1 | Hash core accepts the byte |

## Verification
The assertions assume a header source that supplies exactly pfx_len bytes and message sources that hold a byte steady until it is taken. They also assume a replay pass is preceded by a capture of at least the replayed low offsets. The stimulus keeps to this. Each header source is loaded with exactly the stated count. The message source presents bytes from a fixed offset pattern and moves on only after a handshake. Every replay follows a capture of 4100 bytes.

// File: rtl/feed_pkg.sv
package feed_pkg;
    typedef enum logic [1:0] {
        M_SINGLE  = 2'd0,
        M_CAPTURE = 2'd1,
        M_REPLAY  = 2'd2,
        M_SPARE   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PFX   = 2'd1,
        PH_MSG   = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;
endpackage

// File: rtl/feed_cache.sv
module feed_cache #(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
        if (rd_en) rd_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/feed_seq.sv
module feed_seq
    import feed_pkg::*;
#(
    parameter int CACHE_BYTES = 4096,
    parameter int LEN_W       = 16,
    parameter int PFX_W       = 7,
    parameter int AW          = $clog2(CACHE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [PFX_W-1:0] pfx_len_i,
    input  logic [LEN_W-1:0] msg_len_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    input  logic [7:0]       pfx_data_i,
    input  logic             pfx_valid_i,
    output logic             pfx_ready_o,
    input  logic [7:0]       msg_data_i,
    input  logic             msg_valid_i,
    input  logic             msg_last_i,
    output logic             msg_ready_o,
    output logic             req_valid_o,
    output logic [LEN_W-1:0] req_offset_o,
    output logic [LEN_W-1:0] req_len_o,
    output logic             out_valid_o,
    output logic             out_last_o,
    output logic             out_sel_cache_o,
    output logic [7:0]       out_data_o,
    input  logic             hs_ready_i,
    output logic             wr_en_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic [7:0]       wr_data_o,
    output logic             rd_en_o,
    output logic [AW-1:0]    rd_addr_o
);
    localparam logic [LEN_W-1:0] CACHE_LIM = LEN_W'(CACHE_BYTES);

    typedef struct packed {
        phase_e           phase;
        mode_e            mode;
        logic [PFX_W-1:0] pfx_len;
        logic [PFX_W-1:0] pfx_cnt;
        logic [LEN_W-1:0] msg_len;
        logic [LEN_W-1:0] msg_cnt;
        logic             out_valid;
        logic             out_last;
        logic             sel_cache;
        logic [7:0]       data;
        logic             err;
        logic             done;
        logic             req_valid;
        logic [LEN_W-1:0] req_offset;
        logic [LEN_W-1:0] req_len;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    ld_ok, is_final, pfx_end, below_cache, from_cache;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.req_valid = 1'b0;
        pfx_ready_o = 1'b0;
        msg_ready_o = 1'b0;
        wr_en_o     = 1'b0;
        rd_en_o     = 1'b0;
        ld_ok       = !s_q.out_valid || hs_ready_i;
        is_final    = (s_q.msg_cnt == s_q.msg_len - LEN_W'(1));
        pfx_end     = (s_q.pfx_cnt == s_q.pfx_len - PFX_W'(1));
        below_cache = (s_q.msg_cnt < CACHE_LIM);
        from_cache  = (s_q.mode == M_REPLAY) && below_cache;

        // hand-off of the held byte
        if (s_q.out_valid && hs_ready_i) begin
            s_d.out_valid = 1'b0;
            if (s_q.out_last) begin
                s_d.out_last = 1'b0;
                s_d.done     = 1'b1;
                s_d.phase    = PH_IDLE;
            end
        end

        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.mode    = mode_e'(mode_i);
                    s_d.pfx_len = pfx_len_i;
                    s_d.msg_len = msg_len_i;
                    s_d.pfx_cnt = '0;
                    s_d.msg_cnt = '0;
                    s_d.err     = 1'b0;
                    if (mode_e'(mode_i) == M_REPLAY) begin
                        s_d.req_valid  = (msg_len_i > CACHE_LIM);
                        s_d.req_offset = CACHE_LIM;
                        s_d.req_len    = (msg_len_i > CACHE_LIM) ? msg_len_i - CACHE_LIM : '0;
                    end else begin
                        s_d.req_valid  = (msg_len_i != '0);
                        s_d.req_offset = '0;
                        s_d.req_len    = msg_len_i;
                    end
                    if (pfx_len_i != '0)      s_d.phase = PH_PFX;
                    else if (msg_len_i != '0) s_d.phase = PH_MSG;
                    else                      s_d.done  = 1'b1;
                end
            end
            PH_PFX: begin
                pfx_ready_o = ld_ok;
                if (pfx_valid_i && ld_ok) begin
                    s_d.out_valid = 1'b1;
                    s_d.sel_cache = 1'b0;
                    s_d.data      = pfx_data_i;
                    s_d.out_last  = pfx_end && (s_q.msg_len == '0);
                    s_d.pfx_cnt   = s_q.pfx_cnt + PFX_W'(1);
                    if (pfx_end) s_d.phase = (s_q.msg_len == '0) ? PH_DRAIN : PH_MSG;
                end
            end
            PH_MSG: begin
                if (from_cache) begin
                    rd_en_o = ld_ok;
                    if (ld_ok) begin
                        s_d.out_valid = 1'b1;
                        s_d.sel_cache = 1'b1;
                        s_d.out_last  = is_final;
                        s_d.msg_cnt   = s_q.msg_cnt + LEN_W'(1);
                        if (is_final) s_d.phase = PH_DRAIN;
                    end
                end else begin
                    msg_ready_o = ld_ok;
                    if (msg_valid_i && ld_ok) begin
                        if (msg_last_i != is_final) begin
                            s_d.err   = 1'b1;
                            s_d.done  = 1'b1;
                            s_d.phase = PH_IDLE;
                        end else begin
                            s_d.out_valid = 1'b1;
                            s_d.sel_cache = 1'b0;
                            s_d.data      = msg_data_i;
                            s_d.out_last  = is_final;
                            wr_en_o       = (s_q.mode == M_CAPTURE) && below_cache;
                            s_d.msg_cnt   = s_q.msg_cnt + LEN_W'(1);
                            if (is_final) s_d.phase = PH_DRAIN;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o          = (s_q.phase != PH_IDLE);
    assign done_o          = s_q.done;
    assign err_o           = s_q.err;
    assign req_valid_o     = s_q.req_valid;
    assign req_offset_o    = s_q.req_offset;
    assign req_len_o       = s_q.req_len;
    assign out_valid_o     = s_q.out_valid;
    assign out_last_o      = s_q.out_last;
    assign out_sel_cache_o = s_q.sel_cache;
    assign out_data_o      = s_q.data;
    assign wr_addr_o       = s_q.msg_cnt[AW-1:0];
    assign wr_data_o       = msg_data_i;
    assign rd_addr_o       = s_q.msg_cnt[AW-1:0];

    // R2: the message stream is opened only once the header count is complete
    p_pfx_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready_o |-> (s_q.pfx_cnt == s_q.pfx_len));

    // R3 / R11: cache writes occur only in capture passes and inside the cache
    p_wr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (s_q.mode == M_CAPTURE) && (s_q.msg_cnt < CACHE_LIM) && msg_valid_i);

    // R4: no external fetch while replaying a cached offset
    p_cache_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_MSG && s_q.mode == M_REPLAY && s_q.msg_cnt < CACHE_LIM) |-> !msg_ready_o);

    // R5: a replay request starts right past the cached range
    p_req_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && s_q.mode == M_REPLAY) |-> (req_offset_o == CACHE_LIM));

    // R5: the request pulse lasts one cycle
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    // R7: a pass ends back in the idle phase
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R10: a running pass keeps its mode and lengths
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(s_q.mode) && $stable(s_q.msg_len) && $stable(s_q.pfx_len));
endmodule

// File: rtl/hash_replay_feeder.sv
module hash_replay_feeder #(
    parameter int CACHE_BYTES = 4096,
    parameter int LEN_W       = 16,
    parameter int PFX_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [PFX_W-1:0] pfx_len,
    input  logic [LEN_W-1:0] msg_len,
    output logic             busy,
    output logic             done,
    output logic             frame_err,
    input  logic [7:0]       pfx_data,
    input  logic             pfx_valid,
    output logic             pfx_ready,
    input  logic [7:0]       msg_data,
    input  logic             msg_valid,
    input  logic             msg_last,
    output logic             msg_ready,
    output logic             req_valid,
    output logic [LEN_W-1:0] req_offset,
    output logic [LEN_W-1:0] req_len,
    output logic [7:0]       hs_data,
    output logic             hs_valid,
    output logic             hs_last,
    input  logic             hs_ready
);
    localparam int AW = $clog2(CACHE_BYTES);

    logic          wr_en, rd_en, sel_cache;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data, held_data;

    feed_seq #(
        .CACHE_BYTES(CACHE_BYTES), .LEN_W(LEN_W), .PFX_W(PFX_W), .AW(AW)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .mode_i(mode), .pfx_len_i(pfx_len), .msg_len_i(msg_len),
        .busy_o(busy), .done_o(done), .err_o(frame_err),
        .pfx_data_i(pfx_data), .pfx_valid_i(pfx_valid), .pfx_ready_o(pfx_ready),
        .msg_data_i(msg_data), .msg_valid_i(msg_valid), .msg_last_i(msg_last),
        .msg_ready_o(msg_ready),
        .req_valid_o(req_valid), .req_offset_o(req_offset), .req_len_o(req_len),
        .out_valid_o(hs_valid), .out_last_o(hs_last), .out_sel_cache_o(sel_cache),
        .out_data_o(held_data), .hs_ready_i(hs_ready),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr)
    );

    feed_cache #(.DEPTH(CACHE_BYTES), .AW(AW)) i_cache (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign hs_data = sel_cache ? rd_data : held_data;

    // R6: a stalled byte is held unchanged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && !hs_ready) |=> hs_valid && $stable(hs_data) && $stable(hs_last));

    // R1: nothing is offered to the hash core while idle after reset
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hs_valid) |-> !pfx_ready && !msg_ready);
endmodule

// File: tb/test_hash_replay_feeder.sv
`timescale 1ns/1ps
module test_hash_replay_feeder;
    localparam int CB = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [6:0]  pfx_len = '0;
    logic [15:0] msg_len = '0;
    logic        busy, done, frame_err;
    logic [7:0]  pfx_data = '0;
    logic        pfx_valid = 1'b0, pfx_ready;
    logic [7:0]  msg_data = '0;
    logic        msg_valid = 1'b0, msg_last = 1'b0, msg_ready;
    logic        req_valid;
    logic [15:0] req_offset, req_len;
    logic [7:0]  hs_data;
    logic        hs_valid, hs_last;
    logic        hs_ready = 1'b1;

    hash_replay_feeder i_hash_replay_feeder (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pfx_len(pfx_len),
        .msg_len(msg_len), .busy(busy), .done(done), .frame_err(frame_err),
        .pfx_data(pfx_data), .pfx_valid(pfx_valid), .pfx_ready(pfx_ready),
        .msg_data(msg_data), .msg_valid(msg_valid), .msg_last(msg_last),
        .msg_ready(msg_ready), .req_valid(req_valid), .req_offset(req_offset),
        .req_len(req_len), .hs_data(hs_data), .hs_valid(hs_valid),
        .hs_last(hs_last), .hs_ready(hs_ready)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    // sources
    int src_seed, src_base, src_cnt, src_idx, src_last_idx;
    int p_seed, p_cnt, p_idx;
    bit stall_on = 1'b0;
    // observations
    logic [7:0] got_data [8192];
    bit         got_last [8192];
    int got_n, mh_n, req_n, done_n, hold_n, hold_bad;
    int req_off_seen, req_len_seen;
    bit err_seen, prev_stall;
    logic [7:0] prev_data;
    logic prev_last;

    function automatic logic [7:0] mpat(int seed, int off);
        return 8'(off) ^ 8'(off >> 5) ^ 8'(seed * 29);
    endfunction

    function automatic logic [7:0] ppat(int seed, int i);
        return 8'(i * 3 + 8'hA0) ^ 8'(seed * 17);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // drive at negedge, observe 1 ns later (before the next rising edge)
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
        hs_ready  = stall_on ? (cyc % 3 != 0) : 1'b1;
        msg_valid = (src_idx < src_cnt) && (!stall_on || (cyc % 5 != 1));
        msg_data  = mpat(src_seed, src_base + src_idx);
        msg_last  = (src_idx == src_last_idx);
        pfx_valid = (p_idx < p_cnt) && (!stall_on || (cyc % 4 != 2));
        pfx_data  = ppat(p_seed, p_idx);
        #1;
        if (rst_n) begin
            if (prev_stall) begin
                hold_n++;
                if (!(hs_valid && hs_data == prev_data && hs_last == prev_last)) hold_bad++;
            end
            prev_stall = hs_valid && !hs_ready;
            prev_data  = hs_data;
            prev_last  = hs_last;
            if (hs_valid && hs_ready) begin
                if (got_n < 8192) begin
                    got_data[got_n] = hs_data;
                    got_last[got_n] = hs_last;
                end
                got_n++;
            end
            if (msg_valid && msg_ready) begin src_idx++; mh_n++; end
            if (pfx_valid && pfx_ready) p_idx++;
            if (req_valid) begin
                req_n++; req_off_seen = req_offset; req_len_seen = req_len;
            end
            if (done) begin done_n++; err_seen = frame_err; end
        end
    end

    task automatic setup(int ps, int pc, int ms, int base, int cnt, int last_idx, bit st);
        p_seed = ps; p_cnt = pc; p_idx = 0;
        src_seed = ms; src_base = base; src_cnt = cnt; src_idx = 0; src_last_idx = last_idx;
        stall_on = st;
        got_n = 0; mh_n = 0; hold_n = 0; hold_bad = 0;
    endtask

    task automatic kick(int md, int pl, int ml);
        @(negedge clk);
        start = 1'b1; mode = 2'(md); pfx_len = 7'(pl); msg_len = 16'(ml);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(int md, int pl, int ml);
        int d0 = done_n;
        kick(md, pl, ml);
        for (int i = 0; i < 40000 && done_n == d0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        src_cnt = 0; p_cnt = 0;
    endtask

    task automatic check_stream(string tag, int pl, int ps, int nm, int seed_lo, int seed_hi, bit want_last);
        int bad_at = -1;
        logic [7:0] e;
        check(got_n == pl + nm, {tag, " byte count"}, got_n, pl + nm);
        for (int i = 0; i < got_n && i < pl + nm && bad_at < 0; i++) begin
            e = (i < pl) ? ppat(ps, i) : mpat((i - pl) < CB ? seed_lo : seed_hi, i - pl);
            if (got_data[i] !== e) bad_at = i;
        end
        if (bad_at >= 0)
            check(1'b0, {tag, " data"}, int'(got_data[bad_at]),
                  int'((bad_at < pl) ? ppat(ps, bad_at)
                       : mpat((bad_at - pl) < CB ? seed_lo : seed_hi, bad_at - pl)));
        else check(1'b1, {tag, " data"}, 0, 0);
        if (want_last) begin
            int nl = 0, pos = -1;
            for (int i = 0; i < got_n && i < 8192; i++) if (got_last[i]) begin nl++; pos = i; end
            check(nl == 1 && pos == got_n - 1, {tag, " R7 last position"}, pos, got_n - 1);
        end
    endtask

    task automatic t_reset();
        check(!hs_valid && !busy && !done && !frame_err, "R1 idle outputs", int'(hs_valid), 0);
        check(!req_valid && !pfx_ready && !msg_ready, "R1 ready/request", int'(msg_ready), 0);
    endtask

    task automatic t_single();
        int r0 = req_n, d0 = done_n;
        setup(1, 5, 3, 0, 10, 9, 1'b0);
        run(0, 5, 10);
        check_stream("R2 single", 5, 1, 10, 3, 3, 1'b1);
        check(req_n == r0 + 1 && req_off_seen == 0, "R5 single offset", req_off_seen, 0);
        check(req_len_seen == 10, "R5 single length", req_len_seen, 10);
        check(done_n == d0 + 1 && !err_seen, "R7 done clean", done_n - d0, 1);
        check(!busy, "R7 idle after pass", int'(busy), 0);
    endtask

    task automatic t_capture();
        setup(2, 64, 7, 0, 4100, 4099, 1'b1);
        run(1, 64, 4100);
        check_stream("R3 capture", 64, 2, 4100, 7, 7, 1'b1);
        check(mh_n == 4100, "R3 external bytes", mh_n, 4100);
        check(hold_n > 0 && hold_bad == 0, "R6 hold under stall", hold_bad, 0);
    endtask

    task automatic t_replay();
        setup(4, 3, 7, CB, 4, 3, 1'b1);
        run(2, 3, 4100);
        check_stream("R4 replay", 3, 4, 4100, 7, 7, 1'b1);
        check(mh_n == 4, "R4 external only past cache", mh_n, 4);
        check(req_off_seen == CB, "R5 replay offset", req_off_seen, CB);
        check(req_len_seen == 4, "R5 replay length", req_len_seen, 4);
        check(hold_bad == 0, "R6 hold in replay", hold_bad, 0);
    endtask

    task automatic t_single_no_write();
        int r0;
        setup(5, 2, 11, 0, 50, 49, 1'b0);
        run(0, 2, 50);
        check_stream("R11 single pass", 2, 5, 50, 11, 11, 1'b1);
        r0 = req_n;
        setup(6, 2, 11, 0, 0, -1, 1'b0);
        run(2, 2, 50);
        check_stream("R11 replay after single", 2, 6, 50, 7, 7, 1'b1);
        check(req_n == r0, "R5 no request for short replay", req_n - r0, 0);
        check(mh_n == 0, "R4 short replay fetches nothing", mh_n, 0);
    endtask

    task automatic t_early();
        int d0 = done_n;
        setup(8, 4, 9, 0, 20, 9, 1'b0);
        run(0, 4, 20);
        check(got_n == 13, "R8 forwarded before early end", got_n, 13);
        check(done_n == d0 + 1 && err_seen, "R8 framing error", int'(err_seen), 1);
        check(!busy && !hs_valid, "R8 pass stopped", int'(busy), 0);
    endtask

    task automatic t_late();
        int d0 = done_n;
        setup(9, 2, 12, 0, 8, 100, 1'b0);
        run(1, 2, 8);
        check(got_n == 9, "R9 forwarded before missing end", got_n, 9);
        check(done_n == d0 + 1 && err_seen, "R9 framing error", int'(err_seen), 1);
    endtask

    task automatic t_busy();
        int d0 = done_n, r0 = req_n;
        setup(10, 2, 13, 0, 30, 29, 1'b1);
        kick(0, 2, 30);
        repeat (10) @(negedge clk);
        start = 1'b1; mode = 2'd1; pfx_len = 7'd1; msg_len = 16'd5;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && done_n == d0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        check_stream("R10 busy start", 2, 10, 30, 13, 13, 1'b1);
        check(done_n == d0 + 1, "R10 one done", done_n - d0, 1);
        check(req_n == r0 + 1, "R10 one request", req_n - r0, 1);
        check(!err_seen, "R10 no error", int'(err_seen), 0);
    endtask

    task automatic t_zero();
        int d0 = done_n, r0 = req_n;
        setup(0, 0, 0, 0, 0, -1, 1'b0);
        run(0, 0, 0);
        check(got_n == 0, "R12 no bytes", got_n, 0);
        check(done_n == d0 + 1 && !err_seen, "R12 done", done_n - d0, 1);
        check(req_n == r0, "R12 no request", req_n - r0, 0);
    endtask

    initial begin
        got_n = 0; mh_n = 0; req_n = 0; done_n = 0; hold_n = 0; hold_bad = 0;
        src_cnt = 0; src_idx = 0; src_last_idx = -1; p_cnt = 0; p_idx = 0;
        src_seed = 0; src_base = 0; p_seed = 0;
        prev_stall = 1'b0; err_seen = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        t_reset();
        t_single();
        t_capture();
        t_replay();
        t_single_no_write();
        t_early();
        t_late();
        t_busy();
        t_zero();
        finish_run();
    end
endmodule